// File: doc/BRIEF.md
# Bit-Scrambling XOR Latch

An 8-bit state register sits behind one 16-bit bus location. A write does not simply store the byte. The current state is first rearranged bit by bit through an 8-entry position map, which gives a scramble mask. The new state is the written byte XORed with that mask. Software that knows the map can predict the sequence of values it reads back. Software that does not know the map cannot.

The byte 0xFF is reserved: writing it returns the state to zero. The position map comes from one of two sources, chosen by a parameter. It can be fixed at build time. It can also be installed once at run time through a configuration port, which accepts only a true permutation. Until a map is present, every write is ignored. An output flag shows whether a map is installed.

Top module: `scramble_latch`

## Requirements
- R1: After reset the state is 0x00 and the read bus returns 0x0000.
- R2: The read bus always returns the state in bits 7:0 and zero in bits 15:8, and reading has no side effect.
- R3: A write with byte enable bit 0 low leaves the state unchanged. Bit 1 of the byte enable and write-data bits 15:8 never affect the state.
- R4: A write of low byte 0xFF, with a map present and byte enable bit 0 high, sets the state to 0x00 on the next clock.
- R5: Any other enabled write sets the state to wdata[7:0] XOR mask. Mask bit map[i] is set exactly when state bit i is 1. Map entry i sits in bits [3i+2:3i] of the map vector.
- R6: In the loadable variant (FIXED_TABLE=0), no map is present after reset, table_ok is 0, and every write is ignored, including 0xFF.
- R7: In the loadable variant, the first cfg_load that carries a permutation of 0..7 installs it, and table_ok rises on the next clock. Every later cfg_load is ignored.
- R8: A cfg_load whose map is not a permutation of 0..7 installs nothing and leaves table_ok at 0.
- R9: In the fixed variant (FIXED_TABLE=1), the TABLE parameter is the map and table_ok is 1 from reset. cfg_load has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 2 | Byte-lane enables; bit 0 gates the state |
| bus_wdata | input | 16 | Write data; only bits 7:0 are used |
| bus_rdata | output | 16 | Read data: zero-extended state |
| cfg_load | input | 1 | Map load strobe (loadable variant) |
| cfg_table | input | 24 | Map to load; entry i in bits [3i+2:3i] |
| table_ok | output | 1 | A map is present |

## Verification
The bench builds two copies on the same bus. One is the loadable variant (FIXED_TABLE=0). It receives the map {5,1,6,2,3,7,4,0}, but only after it has been offered a non-permutation. The other is the fixed variant (FIXED_TABLE=1) with the map {6,0,5,3,1,4,2,7}. With two copies, the ignored writes of the loadable copy can be compared in the same cycle with the live copy. Each copy is also checked against its own map over directed and random write streams, and each can be shown to ignore a later map load.

// File: rtl/scramble_latch.sv
module scramble_latch #(
  parameter int DATA_W      = 16,
  parameter int LATCH_W     = 8,
  parameter bit FIXED_TABLE = 1'b0,
  parameter logic [LATCH_W*$clog2(LATCH_W)-1:0] TABLE = 24'h13B58D
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_we,
  input  logic [DATA_W/8-1:0]               bus_be,
  input  logic [DATA_W-1:0]                 bus_wdata,
  output logic [DATA_W-1:0]                 bus_rdata,
  input  logic                              cfg_load,
  input  logic [LATCH_W*$clog2(LATCH_W)-1:0] cfg_table,
  output logic                              table_ok
);
  localparam int IDX_W = $clog2(LATCH_W);
  localparam int TAB_W = LATCH_W * IDX_W;

  function automatic logic is_perm(input logic [TAB_W-1:0] t);
    logic [LATCH_W-1:0] seen;
    seen = '0;
    for (int i = 0; i < LATCH_W; i++) seen[t[i*IDX_W +: IDX_W]] = 1'b1;
    return &seen;
  endfunction

  logic [LATCH_W-1:0] state_q, mask;
  logic [TAB_W-1:0]   map_q;
  logic [LATCH_W-1:0] wbyte;
  logic               wr_hit;

  generate
    if (FIXED_TABLE) begin : g_fixed
      assign map_q    = TABLE;
      assign table_ok = 1'b1;
    end else begin : g_load
      logic [TAB_W-1:0] map_r;
      logic             ok_r;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          map_r <= '0;
          ok_r  <= 1'b0;
        end else if (cfg_load && !ok_r && is_perm(cfg_table)) begin
          map_r <= cfg_table;
          ok_r  <= 1'b1;
        end
      end
      assign map_q    = map_r;
      assign table_ok = ok_r;

      p_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        table_ok |=> table_ok && $stable(map_q));
      p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && !table_ok && !is_perm(cfg_table)) |=> !table_ok);
    end
  endgenerate

  always_comb begin
    mask = '0;
    for (int i = 0; i < LATCH_W; i++)
      if (state_q[i]) mask[map_q[i*IDX_W +: IDX_W]] = 1'b1;
  end

  assign wbyte  = bus_wdata[LATCH_W-1:0];
  assign wr_hit = bus_we && bus_be[0] && table_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)      state_q <= '0;
    else if (wr_hit) state_q <= (&wbyte) ? '0 : (wbyte ^ mask);
  end

  assign bus_rdata = {{(DATA_W-LATCH_W){1'b0}}, state_q};

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we || !bus_be[0]) |=> $stable(bus_rdata));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (&wbyte)) |=> (bus_rdata == '0));
  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    table_ok |-> ($countones(mask) == $countones(state_q)));
  p_nomap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !table_ok |=> $stable(bus_rdata));
  p_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    table_ok |-> is_perm(map_q));
endmodule

// File: tb/scramble_latch_tb.sv
`timescale 1ns/1ps
module scramble_latch_tb;
  localparam real CLK_NS = 4.0;
  localparam logic [23:0] MAP_A = 24'h13B58D; // {5,1,6,2,3,7,4,0}
  localparam logic [23:0] MAP_B = 24'hEA1746; // {6,0,5,3,1,4,2,7}

  logic clk = 0, rst_n = 0, bus_we = 0, cfg_load = 0;
  logic [1:0] bus_be = 0;
  logic [15:0] bus_wdata = 0;
  logic [23:0] cfg_table = 0;
  logic [15:0] rd_a, rd_b;
  logic ok_a, ok_b;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  scramble_latch #(.FIXED_TABLE(1'b0)) u_dut (
    .clk, .rst_n, .bus_we, .bus_be, .bus_wdata, .bus_rdata(rd_a),
    .cfg_load, .cfg_table, .table_ok(ok_a));
  scramble_latch #(.FIXED_TABLE(1'b1), .TABLE(MAP_B)) u_dut_fix (
    .clk, .rst_n, .bus_we, .bus_be, .bus_wdata, .bus_rdata(rd_b),
    .cfg_load, .cfg_table, .table_ok(ok_b));

  // reference model
  int  map_a[8], map_b[8];
  bit  m_ok_a = 0;
  logic [7:0] m_a = 0, m_b = 0;

  logic [15:0] qa[$], qb[$];
  string       qtag[$];

  function automatic bit perm_ok(input logic [23:0] t);
    int cnt[8];
    for (int i = 0; i < 8; i++) cnt[i] = 0;
    for (int i = 0; i < 8; i++) cnt[(t >> (3*i)) & 7]++;
    for (int i = 0; i < 8; i++) if (cnt[i] != 1) return 0;
    return 1;
  endfunction

  function automatic logic [7:0] model_next(input logic [7:0] s, input int m[8], input logic [7:0] d);
    logic [7:0] k = 0;
    if (d == 8'hFF) return 8'h00;
    for (int i = 0; i < 8; i++) if (s[i]) k = k | (8'h01 << m[i]);
    return d ^ k;
  endfunction

  task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d, input string tag);
    @(negedge clk);
    bus_we = 1; bus_be = be; bus_wdata = d;
    @(posedge clk);
    if (be[0]) begin
      if (m_ok_a) m_a = model_next(m_a, map_a, d[7:0]);
      m_b = model_next(m_b, map_b, d[7:0]);
    end
    qa.push_back({8'h00, m_a});
    qb.push_back({8'h00, m_b});
    qtag.push_back(tag);
    @(negedge clk);
    bus_we = 0; bus_be = 0; bus_wdata = 0;
  endtask

  task automatic load(input logic [23:0] t);
    @(negedge clk);
    cfg_load = 1; cfg_table = t;
    @(posedge clk);
    if (!m_ok_a && perm_ok(t)) begin
      m_ok_a = 1;
      for (int i = 0; i < 8; i++) map_a[i] = (t >> (3*i)) & 7;
    end
    @(negedge clk);
    cfg_load = 0; cfg_table = 0;
  endtask

  // monitor: compare both copies against the scoreboard
  always @(negedge clk) begin
    if (qa.size() > 0) begin
      logic [15:0] ea, eb;
      string t;
      ea = qa.pop_front(); eb = qb.pop_front(); t = qtag.pop_front();
      chk(rd_a === ea, {t, " loadable"}, rd_a, ea);
      chk(rd_b === eb, {t, " fixed"},    rd_b, eb);
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) map_b[i] = (MAP_B >> (3*i)) & 7;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(rd_a === 16'h0, "R1 reset loadable", rd_a, 0);
    chk(rd_b === 16'h0, "R1 reset fixed", rd_b, 0);
    chk(ok_a === 1'b0, "R6 no map after reset", ok_a, 0);
    chk(ok_b === 1'b1, "R9 fixed map present", ok_b, 1);

    wr(2'b11, 16'h005A, "R6 write without map");
    wr(2'b01, 16'h00FF, "R6 clear without map");
    wr(2'b01, 16'h0033, "R6 second write without map");

    load(24'h000000);
    @(negedge clk);
    chk(ok_a === 1'b0, "R8 non-permutation rejected", ok_a, 0);
    load(24'hFFFFFF);
    @(negedge clk);
    chk(ok_a === 1'b0, "R8 repeated-entry map rejected", ok_a, 0);

    load(MAP_A);
    @(negedge clk);
    chk(ok_a === 1'b1, "R7 map installed", ok_a, 1);

    wr(2'b01, 16'h0001, "R5 single bit");
    wr(2'b01, 16'h0000, "R5 pure scramble");
    wr(2'b01, 16'h0000, "R5 scramble again");
    wr(2'b10, 16'h00C3, "R3 low lane disabled");
    wr(2'b11, 16'hAB12, "R3 upper data ignored");
    wr(2'b01, 16'h0080, "R5 top bit");
    wr(2'b01, 16'h00FF, "R4 clear");
    wr(2'b01, 16'h00FE, "R5 near-clear value");
    wr(2'b01, 16'h0000, "R5 scramble of FE");

    load(MAP_B);
    @(negedge clk);
    chk(ok_a === 1'b1, "R7 flag stays after second load", ok_a, 1);
    wr(2'b01, 16'h0011, "R7 R9 later load ignored");
    wr(2'b01, 16'h0000, "R7 R9 later load ignored, scramble");

    @(negedge clk);
    chk(rd_a[15:8] === 8'h00, "R2 upper read bits", rd_a[15:8], 0);

    for (int n = 0; n < 300; n++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if (n % 37 == 0) d[7:0] = 8'hFF;
      wr(2'($urandom), d, "R5 random stream");
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule